// File: doc/BRIEF.md
# Half-Duplex Transmit/Receive Mode Controller

This block sequences a half-duplex line modem between sending and listening. A host drives a level select (high asks for receive, low asks for transmit), along with transmit data, a carrier flag that is low while a carrier is heard, and the demodulated bit stream. The controller works out the active mode, and it cuts a transmission that has run too long. It then gates the received-data output, drives a complementary pair of bias-control outputs for the external power amplifier, and drives the enable of the transmit output stage.

Once the transmit hold limit is reached, the controller parks in a timed-out state that behaves like receive. The host can leave that state only by raising the select for a minimum number of cycles, and then it may ask for transmit again. Two test inputs change the timing. One removes the timeout, so that the mode tracks the select directly. The other swaps the long hold limit for a short one.

Every input is asynchronous and passes through a synchronizer before it is used. All signals here are plain levels with no flow control, so the block has no valid/ready interface and never applies back-pressure. The host and the demodulator can change their inputs at any time.

Top module: `hdx_mode_ctrl`

## Requirements
- R1: While in receive mode, a low select (`rx_sel` = 0) moves the block to transmit, and `tx_mode` reads 1 while transmit is active.
- R2: While in transmit, a high select returns the block to receive before the hold limit is reached.
- R3: When the select stays low, transmit lasts exactly `TX_HOLD_CYC` clock cycles. The block then enters the timed-out state and `tx_mode` drops to 0.
- R4: When `tst_fast` = 1, the transmit hold limit becomes `TX_HOLD_FAST_CYC` cycles.
- R5: The block leaves the timed-out state only after the synchronized select has been high for `REARM_CYC` consecutive cycles. A shorter high pulse that is followed by a low select leaves the block timed out.
- R6: When `tst_no_tmo` = 1, transmit never times out. From the timed-out state the mode follows the select directly: low gives transmit, high gives receive.
- R7: While transmit is active, `rxd` = 1.
- R8: Outside transmit, `rxd` equals `demod_bit` when `carrier_n` = 0. When `carrier_n` = 1, `rxd` is 1, except when `rx_sel` = 1 and `tx_bit` = 0; in that case `rxd` equals `demod_bit` whatever the value of `carrier_n`.
- R9: In transmit, `pa_bias` = 1, `pa_bias_n` = 0 and `tx_out_en` = 1. In receive or timed-out they are 0, 1 and 0.
- R10: Each input passes through `SYNC_STAGES` flops. With the default of 2, a low select applied before clock edge 1 sets `tx_mode` after edge 3 and not after edge 2.
- R11: During and after reset the block is in receive, with `tx_mode` = 0, `rxd` = 1, `pa_bias` = 0, `pa_bias_n` = 1 and `tx_out_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modem master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sel | input | 1 | Host mode select, 1 = receive, 0 = transmit |
| tx_bit | input | 1 | Host transmit data |
| carrier_n | input | 1 | Carrier flag, 0 while a carrier is present |
| demod_bit | input | 1 | Demodulated receive bit |
| tst_no_tmo | input | 1 | Test: disable the transmit timeout |
| tst_fast | input | 1 | Test: use the short hold limit |
| tx_mode | output | 1 | 1 while transmit is active |
| rxd | output | 1 | Gated receive data to the host |
| pa_bias | output | 1 | Amplifier bias control, high in transmit |
| pa_bias_n | output | 1 | Complement of `pa_bias` |
| tx_out_en | output | 1 | Transmit output stage enable, 0 = high impedance |

## Verification
The hardest situation to reach from the ports is the edge of the re-arm window in the timed-out state. The block must first be held in transmit for the whole hold limit, and then the select must rise for a pulse exactly one cycle short of `REARM_CYC` and, separately, a pulse of exactly that length. The bench overrides the hold limits with small values so the timeout comes within a few hundred cycles. It drives the select on falling edges and counts rising edges, so the synchronized pulse width equals the driven width. It then checks that the short pulse leaves the block parked and that the exact pulse allows transmit again.

// File: rtl/hdx_pkg.sv
`timescale 1ns/1ps
package hdx_pkg;
  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_TX   = 2'd1,
    ST_TOUT = 2'd2
  } mode_e;

  // bit positions inside the synchronized input bundle
  localparam int B_SEL   = 5;
  localparam int B_TXD   = 4;
  localparam int B_CARN  = 3;
  localparam int B_DEMOD = 2;
  localparam int B_NOTMO = 1;
  localparam int B_FAST  = 0;
  localparam int BUNDLE_W = 6;
endpackage

// File: rtl/hdx_sync.sv
`timescale 1ns/1ps
module hdx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hdx_span_cnt.sv
`timescale 1ns/1ps
module hdx_span_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  // hit in the cycle that completes `limit` consecutive run cycles
  assign hit = run && (cnt >= limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hdx_mode_fsm.sv
`timescale 1ns/1ps
module hdx_mode_fsm
  import hdx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel_s,
  input  logic  no_tmo_s,
  input  logic  tx_expired,
  input  logic  rearm_done,
  output mode_e state
);
  mode_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RX:   if (!sel_s) nxt = ST_TX;
      ST_TX: begin
        if (sel_s)                        nxt = ST_RX;
        else if (tx_expired && !no_tmo_s) nxt = ST_TOUT;
      end
      ST_TOUT: begin
        if (no_tmo_s)        nxt = sel_s ? ST_RX : ST_TX;
        else if (rearm_done) nxt = ST_RX;
      end
      default: nxt = ST_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RX;
    else        state <= nxt;
  end
endmodule

// File: rtl/hdx_out_stage.sv
`timescale 1ns/1ps
module hdx_out_stage (
  input  logic tx_active,
  input  logic sel_s,
  input  logic txd_s,
  input  logic carn_s,
  input  logic demod_s,
  output logic rxd,
  output logic pa_bias,
  output logic pa_bias_n,
  output logic tx_out_en
);
  logic pass_demod;

  assign pass_demod = !carn_s || (sel_s && !txd_s);

  always_comb begin
    if (tx_active)       rxd = 1'b1;
    else if (pass_demod) rxd = demod_s;
    else                 rxd = 1'b1;
  end

  assign pa_bias   = tx_active;
  assign pa_bias_n = !tx_active;
  assign tx_out_en = tx_active;
endmodule

// File: rtl/hdx_mode_ctrl.sv
`timescale 1ns/1ps
module hdx_mode_ctrl
  import hdx_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int TX_HOLD_CYC      = 11059200,
  parameter int TX_HOLD_FAST_CYC = 5397,
  parameter int REARM_CYC        = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_sel,
  input  logic tx_bit,
  input  logic carrier_n,
  input  logic demod_bit,
  input  logic tst_no_tmo,
  input  logic tst_fast,
  output logic tx_mode,
  output logic rxd,
  output logic pa_bias,
  output logic pa_bias_n,
  output logic tx_out_en
);
  localparam int TW = $clog2(TX_HOLD_CYC + 1);
  localparam int RW = $clog2(REARM_CYC + 1);
  localparam logic [BUNDLE_W-1:0] IN_RST = 6'b111100;

  logic [BUNDLE_W-1:0] raw_in, syn_in;
  logic sel_s, txd_s, carn_s, demod_s, no_tmo_s, fast_s;
  logic tx_expired, rearm_done;
  logic [TW-1:0] hold_lim;
  mode_e state;

  assign raw_in = {rx_sel, tx_bit, carrier_n, demod_bit, tst_no_tmo, tst_fast};

  hdx_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign sel_s    = syn_in[B_SEL];
  assign txd_s    = syn_in[B_TXD];
  assign carn_s   = syn_in[B_CARN];
  assign demod_s  = syn_in[B_DEMOD];
  assign no_tmo_s = syn_in[B_NOTMO];
  assign fast_s   = syn_in[B_FAST];

  assign hold_lim = fast_s ? TW'(TX_HOLD_FAST_CYC) : TW'(TX_HOLD_CYC);

  hdx_span_cnt #(.W(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(state == ST_TX), .limit(hold_lim), .hit(tx_expired)
  );

  hdx_span_cnt #(.W(RW)) u_rearm (
    .clk(clk), .rst_n(rst_n), .run((state == ST_TOUT) && sel_s),
    .limit(RW'(REARM_CYC)), .hit(rearm_done)
  );

  hdx_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .no_tmo_s(no_tmo_s),
    .tx_expired(tx_expired), .rearm_done(rearm_done), .state(state)
  );

  assign tx_mode = (state == ST_TX);

  hdx_out_stage u_out (
    .tx_active(tx_mode), .sel_s(sel_s), .txd_s(txd_s), .carn_s(carn_s),
    .demod_s(demod_s), .rxd(rxd), .pa_bias(pa_bias), .pa_bias_n(pa_bias_n),
    .tx_out_en(tx_out_en)
  );
endmodule

// File: rtl/hdx_mode_ctrl_chk.sv
`timescale 1ns/1ps
module hdx_mode_ctrl_chk
  import hdx_pkg::*;
#(
  parameter int TX_HOLD_CYC = 16,
  parameter int REARM_CYC   = 4
) (
  input logic  clk,
  input logic  rst_n,
  input mode_e state,
  input logic  sel_s,
  input logic  no_tmo_s,
  input logic  tx_mode,
  input logic  rxd,
  input logic  pa_bias,
  input logic  pa_bias_n,
  input logic  tx_out_en
);
  localparam int TW = $clog2(TX_HOLD_CYC + 1);
  localparam int RW = $clog2(REARM_CYC + 1);

  logic [TW-1:0] tx_run;
  logic [RW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= '0;
      hi_run <= '0;
    end else begin
      if (state != ST_TX)                tx_run <= '0;
      else if (tx_run != TW'(TX_HOLD_CYC)) tx_run <= tx_run + 1'b1;
      if (!sel_s)                        hi_run <= '0;
      else if (hi_run != RW'(REARM_CYC)) hi_run <= hi_run + 1'b1;
    end
  end

  AST_TX_RXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode |-> rxd); // R7

  AST_IDLE_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_TX) |-> (!pa_bias && pa_bias_n && !tx_out_en)); // R9

  AST_TX_ON_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX) |-> (pa_bias && !pa_bias_n && tx_out_en)); // R9

  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && sel_s) |=> (state == ST_RX)); // R2

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && !no_tmo_s && tx_run >= TW'(TX_HOLD_CYC - 1)) |=> (state != ST_TX)); // R3

  AST_TOUT_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TOUT && !no_tmo_s) |=> (state != ST_TX)); // R5

  AST_REARM_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_TOUT && state == ST_RX && !$past(no_tmo_s))
      |-> (hi_run >= RW'(REARM_CYC))); // R5
endmodule

bind hdx_mode_ctrl hdx_mode_ctrl_chk #(
  .TX_HOLD_CYC(TX_HOLD_CYC), .REARM_CYC(REARM_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .sel_s(sel_s), .no_tmo_s(no_tmo_s),
  .tx_mode(tx_mode), .rxd(rxd), .pa_bias(pa_bias), .pa_bias_n(pa_bias_n),
  .tx_out_en(tx_out_en)
);

// File: tb/hdx_mode_ctrl_test.sv
`timescale 1ns/1ps
module hdx_mode_ctrl_test;
  localparam int HOLD  = 400;
  localparam int FASTH = 100;
  localparam int REARM = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sel = 1'b1, tx_bit = 1'b1, carrier_n = 1'b1, demod_bit = 1'b1;
  logic tst_no_tmo = 1'b0, tst_fast = 1'b0;
  logic tx_mode, rxd, pa_bias, pa_bias_n, tx_out_en;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hdx_mode_ctrl #(
    .SYNC_STAGES(2), .TX_HOLD_CYC(HOLD), .TX_HOLD_FAST_CYC(FASTH), .REARM_CYC(REARM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .tx_bit(tx_bit), .carrier_n(carrier_n),
    .demod_bit(demod_bit), .tst_no_tmo(tst_no_tmo), .tst_fast(tst_fast),
    .tx_mode(tx_mode), .rxd(rxd), .pa_bias(pa_bias), .pa_bias_n(pa_bias_n),
    .tx_out_en(tx_out_en)
  );

  // {rx_sel, tx_bit, carrier_n, demod_bit, exp_tx_mode, exp_rxd}
  localparam logic [5:0] VEC [10] = '{
    6'b1100_00, // R8 carrier present, demod 0 passes
    6'b1101_01, // R8 carrier present, demod 1 passes
    6'b1110_01, // R8 no carrier forces 1
    6'b1010_00, // R8 bypass sel=1 txd=0
    6'b1011_01, // R8 bypass demod 1
    6'b1000_00, // R8 bypass with carrier
    6'b0100_11, // R1 R7 transmit
    6'b0010_11, // R7
    6'b0110_11, // R7
    6'b1100_00  // R2 back to receive
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic m, input logic r);
    logic [4:0] act, exp;
    act = {tx_mode, rxd, pa_bias, pa_bias_n, tx_out_en};
    exp = {m, r, m, !m, m};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {mode,rxd,bias,bias_n,oe} act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    chk_out("R11 in reset", 1'b0, 1'b1);
    rst_n = 1'b1;
    tick(4);
    chk_out("R11 after reset", 1'b0, 1'b1);

    for (int i = 0; i < 10; i++) begin
      {rx_sel, tx_bit, carrier_n, demod_bit} = VEC[i][5:2];
      tick(5);
      chk_out($sformatf("R8/R7/R9 vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R10 latency
    tx_bit = 1'b1; carrier_n = 1'b1;
    rx_sel = 1'b0;
    tick(2);
    chk_out("R10 not yet after edge 2", 1'b0, 1'b1);
    tick(1);
    chk_out("R10 transmit after edge 3", 1'b1, 1'b1);

    // R3 full hold
    tick(HOLD - 1);
    chk_out("R3 still transmitting at limit-1", 1'b1, 1'b1);
    tick(1);
    chk_out("R3 timed out at limit", 1'b0, 1'b1);
    carrier_n = 1'b0; demod_bit = 1'b0;
    tick(4);
    chk_out("R8 timed-out passes demod", 1'b0, 1'b0);
    carrier_n = 1'b1; demod_bit = 1'b1;
    tick(4);

    // R5 short re-arm pulse
    rx_sel = 1'b1;
    tick(REARM - 1);
    rx_sel = 1'b0;
    tick(12);
    chk_out("R5 short pulse stays timed out", 1'b0, 1'b1);

    // R5 exact re-arm pulse
    rx_sel = 1'b1;
    tick(REARM);
    rx_sel = 1'b0;
    tick(6);
    chk_out("R5 exact pulse allows transmit", 1'b1, 1'b1);

    // R4 fast limit
    rx_sel = 1'b1;
    tst_fast = 1'b1;
    tick(6);
    chk_out("R2 released to receive", 1'b0, 1'b1);
    rx_sel = 1'b0;
    tick(3);
    chk_out("R4 transmit started", 1'b1, 1'b1);
    tick(FASTH - 1);
    chk_out("R4 still transmitting at fast limit-1", 1'b1, 1'b1);
    tick(1);
    chk_out("R4 timed out at fast limit", 1'b0, 1'b1);

    // R6 timeout disabled
    tst_no_tmo = 1'b1;
    tst_fast = 1'b0;
    tick(4);
    chk_out("R6 timed-out follows low select", 1'b1, 1'b1);
    tick(HOLD + 50);
    chk_out("R6 no timeout past limit", 1'b1, 1'b1);
    rx_sel = 1'b1;
    tick(4);
    chk_out("R6 follows high select", 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule